// File: doc/BRIEF.md
# Rate-1/2 Constraint-Length-7 Convolutional Encoder

This block turns a stream of user data bits into a stream of coded symbol pairs. It uses a constraint-length-7, rate-1/2 convolutional code, and each accepted data bit yields exactly one pair of symbols. Inside is a six-bit memory of past bits. Together with the incoming bit, that memory forms a seven-stage window, and two fixed parity taps over the window produce the two symbols. In the larger chip the block is the stimulus source for a Viterbi decoder: whatever it emits is a valid codeword that the decoder can be checked against.

Data enters on a valid/ready handshake. A bit flagged as the start of a frame first clears the memory, so the frame is coded from the all-zero state. A bit flagged as the end of a frame starts an automatic flush. The encoder then generates six zero bits on its own and emits their symbol pairs, which leaves both the encoder and any decoder that follows in state zero. Symbol pairs leave through a registered valid/ready output stage. A one-cycle done pulse follows the hand-off of the final flush pair.

Top module: `conv_k7_encoder`

## Requirements
- R1: After a synchronous reset, `out_valid` and `done` are low, `in_ready` is high, and the bit memory is zero, so a following frame without a start flag is coded from the zero state.
- R2: Stage 1 is the bit being accepted, and stage n (n = 2..7) is the bit accepted n-1 bits earlier in the frame. The first symbol, carried on `out_pair[1]`, is the XOR of stages 1, 3, 4, 6 and 7.
- R3: The second symbol, carried on `out_pair[0]`, is the XOR of stages 1, 2, 3, 4 and 7.
- R4: Each accepted bit produces exactly one symbol pair, in acceptance order. The pair appears with `out_valid` high on the cycle after acceptance. `out_pair` and `out_tail` stay unchanged while `out_valid` is high and `out_ready` is low.
- R5: A bit accepted with `in_first` high is coded as if all six earlier stages were zero, whatever bits came before it, including an unfinished frame.
- R6: A bit accepted with `in_last` high is followed by exactly six more pairs. These are produced by zero input bits and flagged with `out_tail` high. `in_ready` is low from the cycle after the last bit is accepted until the sixth flush bit has been generated.
- R7: `done` is high for exactly one cycle: the cycle after the sixth flush pair is accepted at the output. It is never high otherwise.
- R8: After a flush the memory is zero, so a next frame sent without `in_first` codes the same as one sent with it.
- R9: With `out_ready` held high and a bit offered every cycle, a bit is accepted on every cycle outside the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | The encoder can take a bit this cycle |
| in_bit | input | 1 | The data bit |
| in_first | input | 1 | This bit opens a frame (memory cleared first) |
| in_last | input | 1 | This bit closes a frame (six-bit zero flush follows) |
| out_valid | output | 1 | A symbol pair is presented |
| out_ready | input | 1 | The consumer takes the presented pair |
| out_pair | output | 2 | Bit 1 = first symbol, bit 0 = second symbol |
| out_tail | output | 1 | The presented pair comes from a flush bit |
| done | output | 1 | One-cycle pulse after the final flush pair is taken |

## Verification
The two symbol equations are tried with several bit patterns. A lone one bit followed by the flush checks the full impulse response against a fixed table, so every tap of both polynomials is tested separately. All-zero and all-one frames test the trivial and saturated parity cases, and mixed words test the memory ordering. The same frames are run under several output back-pressure and source-gap patterns, which separates a wrong pair order or lost pairs from a wrong parity. An abandoned frame followed by a start-flagged frame, a frame sent without a start flag after a flush, and a reset in the middle of a frame test the clearing rules.

// File: rtl/conv_k7_pkg.sv
package conv_k7_pkg;
  // Window bit i holds stage i+1; stage 1 is the bit entering this cycle.
  localparam int unsigned CONSTRAINT = 7;
  localparam int unsigned SYMS       = 2;
  localparam logic [CONSTRAINT-1:0] TAPS_FIRST  = 7'b1101101; // stages 1,3,4,6,7
  localparam logic [CONSTRAINT-1:0] TAPS_SECOND = 7'b1001111; // stages 1,2,3,4,7
endpackage

// File: rtl/conv_k7_history.sv
module conv_k7_history #(
  parameter int unsigned MEM = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           clear,
  input  logic           din,
  output logic [MEM:0]   window
);
  logic [MEM-1:0] past_q;
  logic [MEM-1:0] base;

  assign base   = clear ? '0 : past_q;
  assign window = {base, din};

  always_ff @(posedge clk) begin
    if (rst)       past_q <= '0;
    else if (step) past_q <= {base[MEM-2:0], din};
  end
endmodule

// File: rtl/conv_k7_symgen.sv
module conv_k7_symgen #(
  parameter int unsigned              K     = 7,
  parameter int unsigned              NSYM  = 2,
  parameter logic [NSYM*K-1:0]        TAPS  = '0
) (
  input  logic [K-1:0]    window,
  output logic [NSYM-1:0] sym
);
  for (genvar g = 0; g < NSYM; g++) begin : g_parity
    assign sym[g] = ^(window & TAPS[g*K +: K]);
  end
endmodule

// File: rtl/conv_k7_tail_ctl.sv
module conv_k7_tail_ctl #(
  parameter int unsigned MEM = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  output logic flushing,
  output logic final_step
);
  localparam int unsigned CW = $clog2(MEM + 1);
  logic [CW-1:0] cnt_q;

  assign flushing   = (cnt_q != '0);
  assign final_step = step && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (start) cnt_q <= CW'(MEM);
    else if (step)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/conv_k7_encoder.sv
module conv_k7_encoder #(
  parameter int unsigned  K       = conv_k7_pkg::CONSTRAINT,
  parameter logic [K-1:0] TAPS_A  = conv_k7_pkg::TAPS_FIRST,
  parameter logic [K-1:0] TAPS_B  = conv_k7_pkg::TAPS_SECOND
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_first,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_pair,
  output logic       out_tail,
  output logic       done
);
  localparam int unsigned MEM  = K - 1;
  localparam int unsigned NSYM = conv_k7_pkg::SYMS;

  logic           slot_free, flushing, final_step;
  logic           take_in, take_tail, step, clear, din;
  logic [K-1:0]   window;
  logic [NSYM-1:0] sym;
  logic           end_q;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !flushing && slot_free;
  assign take_in   = in_valid && in_ready;
  assign take_tail = flushing && slot_free;
  assign step      = take_in || take_tail;
  assign clear     = take_in && in_first;
  assign din       = take_in && in_bit;

  conv_k7_history #(.MEM(MEM)) u_hist (
    .clk(clk), .rst(rst), .step(step), .clear(clear), .din(din), .window(window)
  );

  conv_k7_symgen #(.K(K), .NSYM(NSYM), .TAPS({TAPS_B, TAPS_A})) u_sym (
    .window(window), .sym(sym)
  );

  conv_k7_tail_ctl #(.MEM(MEM)) u_tail (
    .clk(clk), .rst(rst), .start(take_in && in_last), .step(take_tail),
    .flushing(flushing), .final_step(final_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pair  <= '0;
      out_tail  <= 1'b0;
      end_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= out_valid && out_ready && end_q;
      if (step) begin
        out_valid <= 1'b1;
        out_pair  <= {sym[0], sym[1]};
        out_tail  <= take_tail;
        end_q     <= final_step;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        end_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_k7_encoder_chk.sv
module conv_k7_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_pair,
  input logic       out_tail,
  input logic       done
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after reset the output side is idle and input is open
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_idle_r1: assert (!out_valid && !done && in_ready);
    end
  end

  // R4: a presented pair is held while the consumer stalls
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pair) && $stable(out_tail));

  // R4: an accepted bit yields a pair on the next cycle
  p_pair_follows_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && !out_tail);

  // R7: done follows the hand-off of a flush pair
  p_done_after_tail_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(out_valid && out_ready && out_tail));

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind conv_k7_encoder conv_k7_encoder_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
  .out_tail(out_tail), .done(done)
);

// File: tb/conv_k7_encoder_test.sv
module conv_k7_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_tail, done;
  logic [1:0] out_pair;

  always #10 clk = ~clk; // 50 MHz

  conv_k7_encoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_first(in_first), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
    .out_tail(out_tail), .done(done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // Stimulus/expected table: length, data (LSB sent first), start flag,
  // output-ready pattern, source-valid pattern, expected pair count.
  localparam int          N_VEC = 8;
  localparam int          V_LEN   [N_VEC] = '{8, 16, 12, 1, 16, 5, 14, 3};
  localparam logic [15:0] V_DATA  [N_VEC] = '{16'h00B5, 16'hA5C3, 16'h0FFF, 16'h0001,
                                              16'hFFFF, 16'h0000, 16'h2D71, 16'h0006};
  localparam bit          V_FIRST [N_VEC] = '{1, 1, 0, 1, 1, 1, 0, 1};
  localparam logic [3:0]  V_RDY   [N_VEC] = '{4'hF, 4'hA, 4'h7, 4'hF, 4'h3, 4'h9, 4'hF, 4'h5};
  localparam logic [3:0]  V_SRC   [N_VEC] = '{4'hF, 4'hF, 4'hD, 4'hF, 4'h6, 4'hF, 4'hB, 4'hF};
  localparam int          V_NPAIR [N_VEC] = '{14, 22, 18, 7, 22, 11, 20, 9};

  // Independent reference: s[n] is stage n
  logic [7:1] s = '0;
  logic [1:0] exp_pair [64];
  bit         exp_tl   [64];
  logic [1:0] cap      [64];
  int n_exp, n_cap, n_done, cyc, first_acc, last_acc;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [1:0] ref_pair(logic [7:1] st);
    ref_pair[1] = st[1] ^ st[3] ^ st[4] ^ st[6] ^ st[7];
    ref_pair[0] = st[1] ^ st[2] ^ st[3] ^ st[4] ^ st[7];
  endfunction

  task automatic model_push(bit b, bit tl);
    s = {s[6:1], b};
    exp_pair[n_exp] = ref_pair(s);
    exp_tl[n_exp]   = tl;
    n_exp++;
  endtask

  task automatic run_frame(int len, logic [15:0] data, bit first, bit last,
                           logic [3:0] rdy, logic [3:0] src);
    int idx = 0;
    int lim = 0;
    bit hold_v = 0;
    logic [2:0] hold_val = '0;
    bit flush_chk = 0;
    n_exp = 0; n_cap = 0; n_done = 0; first_acc = -1; last_acc = -1;
    while (lim < 600) begin
      @(negedge clk);
      cyc++; lim++;
      if (hold_v && out_valid)
        chk({out_pair, out_tail} == hold_val, "R4 stall hold", int'({out_pair, out_tail}), int'(hold_val));
      out_ready = rdy[cyc % 4];
      in_valid  = (idx < len) && src[cyc % 4];
      in_bit    = data[idx % 16];
      in_first  = first && (idx == 0);
      in_last   = last && (idx == len - 1);
      #1;
      if (flush_chk) begin
        chk(in_ready == 1'b0, "R6 input closed during flush", int'(in_ready), 0);
        flush_chk = 0;
      end
      hold_v   = out_valid && !out_ready;
      hold_val = {out_pair, out_tail};
      if (out_valid && out_ready) begin
        chk(n_cap < n_exp, "R4 extra pair", n_cap, n_exp);
        if (n_cap < n_exp)
          chk({out_pair, out_tail} == {exp_pair[n_cap], exp_tl[n_cap]},
              "R2 R3 R6 pair/tail", int'({out_pair, out_tail}),
              int'({exp_pair[n_cap], exp_tl[n_cap]}));
        cap[n_cap] = out_pair;
        n_cap++;
      end
      if (done) begin
        n_done++;
        chk(last && n_cap == n_exp && n_exp == len + 6, "R7 done timing", n_cap, len + 6);
      end
      if (in_valid && in_ready) begin
        if (in_first) s = '0;
        model_push(in_bit, 1'b0);
        if (first_acc < 0) first_acc = cyc;
        last_acc = cyc;
        idx++;
        if (in_last) begin
          for (int t = 0; t < 6; t++) model_push(1'b0, 1'b1);
          flush_chk = 1;
        end
      end
      if (last && n_done > 0 && lim > 2 && !done) break;
      if (!last && idx == len && n_cap == n_exp) break;
    end
    in_valid = 0; in_first = 0; in_last = 0;
    chk(n_cap == n_exp, "R4 pair count", n_cap, n_exp);
    if (last) chk(n_done == 1, "R7 single done", n_done, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk); #1;
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(done == 0, "R1 done after reset", int'(done), 0);
    chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);

    for (int v = 0; v < N_VEC; v++) begin
      run_frame(V_LEN[v], V_DATA[v], V_FIRST[v], 1'b1, V_RDY[v], V_SRC[v]);
      chk(n_cap == V_NPAIR[v], "R6 frame length plus six", n_cap, V_NPAIR[v]);
      if (V_RDY[v] == 4'hF && V_SRC[v] == 4'hF)
        chk(last_acc - first_acc == V_LEN[v] - 1, "R9 one bit per cycle",
            last_acc - first_acc, V_LEN[v] - 1);
      if (v == 3)  // impulse response of both taps (R2 R3)
        chk({cap[0], cap[1], cap[2], cap[3], cap[4], cap[5], cap[6]} == 14'b11_01_11_11_00_10_11,
            "R2 R3 impulse", int'({cap[0], cap[1], cap[2], cap[3], cap[4], cap[5], cap[6]}),
            int'(14'b11_01_11_11_00_10_11));
      if (v == 2 || v == 6)  // no start flag after a flush (R8)
        chk(n_cap == V_NPAIR[v], "R8 coded from zero after flush", n_cap, V_NPAIR[v]);
    end

    // R5: abandoned frame, then a start-flagged frame
    run_frame(5, 16'h001F, 1'b1, 1'b0, 4'hF, 4'hF);
    run_frame(6, 16'h002A, 1'b1, 1'b1, 4'hB, 4'hF);
    chk(n_cap == 12, "R5 restart after abandoned frame", n_cap, 12);

    // R1: reset in mid frame, then a frame with no start flag
    run_frame(4, 16'h000F, 1'b1, 1'b0, 4'hF, 4'hF);
    @(negedge clk); out_ready = 0; rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(out_valid == 0, "R1 mid-frame reset clears output", int'(out_valid), 0);
    chk(in_ready == 1, "R1 mid-frame reset opens input", int'(in_ready), 1);
    s = '0;
    run_frame(7, 16'h005B, 1'b0, 1'b1, 4'hF, 4'hF);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule